// File: doc/BRIEF.md
# Request-Driven Pipelined Bus Master

This block turns a simple local request port into pipelined single-master bus transfers. The local side presents a valid strobe, a write or read select, an address, write data and a last-beat marker for every beat of a sequence. The block raises its bus request, waits for grant and ready, and then pulls beats from the local side one per free cycle. Each pull is announced by a combinational take strobe, so the local side advances its pointer on the same clock edge that the block registers the beat.

The bus side follows the usual two-stage pipeline. The address and control of one beat overlap the data phase of the beat before it. A low ready freezes both stages. The first beat of a sequence is marked non-sequential and the beats after it sequential. A lock flag covers the sequence and falls on its final beat. A two-cycle error response cancels the sequence. Read data is returned to the local side one cycle after it is accepted, and a strobe marks that cycle.

Top module: `rqm_master`

## Requirements
- R1: `bus_req` is high exactly when `lreq_valid` is high, except in the cycle that completes an error response and in every cycle after it until `lreq_valid` has been low at a clock edge.
- R2: A beat taken while `lreq_wr`=1 and `lreq_rd`=0 is issued with `bus_write`=1. A beat taken while `lreq_rd`=1 is issued with `bus_write`=0.
- R3: `bus_size` is always 3'b010 (32-bit word), and both data buses are 32 bits wide.
- R4: Transfer type encoding: IDLE=2'b00, NONSEQ=2'b10, SEQ=2'b11. The first beat of a sequence goes out as NONSEQ. Every later beat of that sequence goes out as SEQ.
- R5: `bus_lock` is high during each beat of a sequence and in idle cycles inside that sequence. It is low during the address phase of the beat taken with `lreq_last`=1.
- R6: While `bus_ready` is low, `bus_addr`, `bus_trans`, `bus_write`, `bus_lock` and `bus_wdata` do not change at the next edge.
- R7: `lreq_addr_take` = `bus_ready` & `bus_gnt` & `bus_req`. When it is high, `lreq_addr` appears on `bus_addr` after the next edge.
- R8: `lreq_wdata_take` is high exactly when `lreq_addr_take` is high for a write. The write data taken with a beat appears on `bus_wdata` in the cycle after that beat's address phase completes.
- R9: Response encoding: OKAY=2'b00, ERROR=2'b01. `lrsp_rdata_vld` is high when a read data phase completes with ready high and OKAY. `bus_rdata` from that cycle appears on `lrsp_rdata` after the next edge.
- R10: If no beat is taken in a cycle where ready is high, `bus_trans` goes to IDLE at the next edge. This covers no pending request and no grant.
- R11: An ERROR response completes when it is seen with ready high during a data phase. After that edge `bus_trans` is IDLE and `bus_lock` is low. Any transfer still in its address phase is dropped.
- R12: While `rst_n` is low, `bus_trans` is IDLE, `bus_lock`, `bus_addr`, `bus_write`, `bus_wdata` and `lrsp_rdata` are zero, and the sequence and error state are cleared.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lreq_valid | input | 1 | Local side has a beat to issue |
| lreq_wr | input | 1 | Beat is a write |
| lreq_rd | input | 1 | Beat is a read |
| lreq_last | input | 1 | Beat is the final one of its sequence |
| lreq_addr | input | ADDR_W | Beat address |
| lreq_wdata | input | DATA_W | Beat write data |
| lrsp_rdata | output | DATA_W | Registered read data |
| lreq_addr_take | output | 1 | Beat address and control taken this cycle |
| lreq_wdata_take | output | 1 | Beat write data taken this cycle |
| lrsp_rdata_vld | output | 1 | Read data accepted this cycle; valid on lrsp_rdata next cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | ADDR_W | Bus address |
| bus_trans | output | 2 | Transfer type |
| bus_write | output | 1 | Transfer direction, 1 = write |
| bus_size | output | 3 | Transfer size code |
| bus_lock | output | 1 | Locked sequence |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_resp | input | 2 | Transfer response |
| bus_rdata | input | DATA_W | Bus read data |

## Verification
The bench builds the block with its defaults, ADDR_W=32 and DATA_W=32. With full 32-bit addresses, random sequence start points reach the top of the address space, and the read and write data patterns derived from the address exercise every data bit. The stimulus runs through phases of different grant and ready densities: full throughput, long runs of wait states, and phases with injected two-cycle error responses. These phases produce back-to-back sequences, stalls landing on first and last beats, and errors arriving with a further beat already in its address phase.

// File: rtl/rqm_pkg.sv
package rqm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;
endpackage

// File: rtl/rqm_addr_phase.sv
module rqm_addr_phase #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic              addr_go,
  input  logic              err_now,
  input  logic              req_valid,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic              last_beat,
  input  logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        trans_o,
  output logic              write_o,
  output logic              lock_o,
  output logic              err_hold_o
);
  import rqm_pkg::*;

  logic [ADDR_W-1:0] addr_q, addr_d;
  trans_e            trans_q, trans_d;
  logic              write_q, write_d;
  logic              lock_q, lock_d;
  logic              in_seq_q, in_seq_d;
  logic              hold_q, hold_d;

  always_comb begin
    addr_d   = addr_q;
    trans_d  = trans_q;
    write_d  = write_q;
    lock_d   = lock_q;
    in_seq_d = in_seq_q;
    if (err_now) begin
      trans_d  = TR_IDLE;
      lock_d   = 1'b0;
      in_seq_d = 1'b0;
    end else if (addr_go) begin
      addr_d   = beat_addr;
      trans_d  = in_seq_q ? TR_SEQ : TR_NSEQ;
      write_d  = wr_sel & ~rd_sel;
      lock_d   = ~last_beat;
      in_seq_d = ~last_beat;
    end else begin
      trans_d  = TR_IDLE;
      lock_d   = in_seq_q;
    end
    if (err_now)         hold_d = 1'b1;
    else if (!req_valid) hold_d = 1'b0;
    else                 hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      trans_q  <= TR_IDLE;
      write_q  <= 1'b0;
      lock_q   <= 1'b0;
      in_seq_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      if (hready) begin
        addr_q   <= addr_d;
        trans_q  <= trans_d;
        write_q  <= write_d;
        lock_q   <= lock_d;
        in_seq_q <= in_seq_d;
      end
      hold_q <= hold_d;
    end
  end

  assign addr_o     = addr_q;
  assign trans_o    = trans_q;
  assign write_o    = write_q;
  assign lock_o     = lock_q;
  assign err_hold_o = hold_q;

  // R6
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(addr_q) && $stable(trans_q) && $stable(write_q) && $stable(lock_q)));

  // R4
  first_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_go && !in_seq_q) |=> (trans_q == TR_NSEQ));

  // R5
  lock_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_go && last_beat) |=> !lock_q);

  // R11
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> (trans_q == TR_IDLE && !lock_q && hold_q));
endmodule

// File: rtl/rqm_data_phase.sv
module rqm_data_phase #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic [1:0]        hresp,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              wd_go,
  input  logic [DATA_W-1:0] beat_wdata,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] loc_rdata_o,
  output logic              rdata_rcv_o,
  output logic              err_now_o
);
  import rqm_pkg::*;

  logic              dp_act_q, dp_wr_q;
  logic [DATA_W-1:0] stage_q, wdata_q, rdata_q;
  logic              addr_active, err_now, rcv;

  assign addr_active = (trans_i == TR_NSEQ) || (trans_i == TR_SEQ);
  assign err_now     = dp_act_q & hready & (hresp == RSP_ERROR);
  assign rcv         = dp_act_q & ~dp_wr_q & hready & (hresp == RSP_OKAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_act_q <= 1'b0;
      dp_wr_q  <= 1'b0;
      stage_q  <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (wd_go) stage_q <= beat_wdata;
      if (hready) begin
        dp_act_q <= addr_active & ~err_now;
        dp_wr_q  <= write_i;
        if (addr_active && write_i && !err_now) wdata_q <= stage_q;
      end
      if (rcv) rdata_q <= rdata_i;
    end
  end

  assign wdata_o     = wdata_q;
  assign loc_rdata_o = rdata_q;
  assign rdata_rcv_o = rcv;
  assign err_now_o   = err_now;

  // R9
  rdata_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcv |=> (rdata_q == $past(rdata_i)));

  // R6
  wdata_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(wdata_q));
endmodule

// File: rtl/rqm_master.sv
module rqm_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq_valid,
  input  logic              lreq_wr,
  input  logic              lreq_rd,
  input  logic              lreq_last,
  input  logic [ADDR_W-1:0] lreq_addr,
  input  logic [DATA_W-1:0] lreq_wdata,
  output logic [DATA_W-1:0] lrsp_rdata,
  output logic              lreq_addr_take,
  output logic              lreq_wdata_take,
  output logic              lrsp_rdata_vld,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_trans,
  output logic              bus_write,
  output logic [2:0]        bus_size,
  output logic              bus_lock,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [1:0]        bus_resp,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

  logic err_now, err_hold, addr_go, wd_go;

  assign bus_req  = lreq_valid & ~err_hold & ~err_now;
  assign addr_go  = bus_ready & bus_gnt & bus_req;
  assign wd_go    = addr_go & lreq_wr & ~lreq_rd;
  assign bus_size = SIZE_CODE;

  assign lreq_addr_take  = addr_go;
  assign lreq_wdata_take = wd_go;

  rqm_addr_phase #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .hready     (bus_ready),
    .addr_go    (addr_go),
    .err_now    (err_now),
    .req_valid  (lreq_valid),
    .wr_sel     (lreq_wr),
    .rd_sel     (lreq_rd),
    .last_beat  (lreq_last),
    .beat_addr  (lreq_addr),
    .addr_o     (bus_addr),
    .trans_o    (bus_trans),
    .write_o    (bus_write),
    .lock_o     (bus_lock),
    .err_hold_o (err_hold)
  );

  rqm_data_phase #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .hready      (bus_ready),
    .hresp       (bus_resp),
    .trans_i     (bus_trans),
    .write_i     (bus_write),
    .rdata_i     (bus_rdata),
    .wd_go       (wd_go),
    .beat_wdata  (lreq_wdata),
    .wdata_o     (bus_wdata),
    .loc_rdata_o (lrsp_rdata),
    .rdata_rcv_o (lrsp_rdata_vld),
    .err_now_o   (err_now)
  );

  // R1
  busreq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> lreq_valid);

  // R8
  wdata_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_wdata_take |-> (lreq_addr_take && lreq_wr));

  // R7
  addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_addr_take |=> (bus_addr == $past(lreq_addr)));
endmodule

// File: tb/rqm_master_tb_top.sv
`timescale 1ns/1ps
module rqm_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lreq_valid, lreq_wr, lreq_rd, lreq_last;
  logic [31:0] lreq_addr, lreq_wdata, lrsp_rdata;
  logic        lreq_addr_take, lreq_wdata_take, lrsp_rdata_vld;
  logic        bus_req, bus_gnt, bus_write, bus_lock, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_trans, bus_resp;
  logic [2:0]  bus_size;

  always #2 clk = ~clk;

  rqm_master #(.ADDR_W(32), .DATA_W(32)) dut_i (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  function automatic logic [31:0] wpat(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] rpat(input logic [31:0] a);
    return ~a + 32'h0001_3579;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver state
  int seq_left = 0, gap_left = 0, err_phase = 0;
  logic [31:0] seq_addr = '0;
  bit seq_wr = 0;
  int gnt_pct, rdy_pct, err_pct;
  // bench model
  bit b_in_seq = 0, b_hold = 0, b_dp_v = 0, b_dp_w = 0;
  logic [31:0] b_dp_a = '0;
  // previous-cycle samples
  bit have_prev = 0;
  bit p_ready, p_err, p_take, p_wr, p_last, p_rvld, p_valid, p_bwrite, p_block;
  logic [31:0] p_addr, p_baddr, p_bwdata, p_dp_a;
  logic [1:0]  p_trans;

  function automatic bit active(input logic [1:0] t);
    return t == 2'b10 || t == 2'b11;
  endfunction

  task automatic check_after();
    if (!p_ready) begin
      chk(bus_trans == p_trans && bus_addr == p_baddr && bus_write == p_bwrite &&
          bus_lock == p_block && bus_wdata == p_bwdata, "R6 hold on wait",
          {bus_trans, bus_lock, bus_addr[27:0]}, {p_trans, p_block, p_baddr[27:0]});
    end else if (p_err) begin
      chk(bus_trans == 2'b00, "R11 idle after error", 32'(bus_trans), 32'd0);
      chk(bus_lock == 1'b0, "R11 lock drop after error", 32'(bus_lock), 32'd0);
    end else if (p_take) begin
      chk(bus_addr == p_addr, "R7 address copied", bus_addr, p_addr);
      chk(bus_trans == (b_in_seq ? 2'b11 : 2'b10), "R4 transfer type",
          32'(bus_trans), b_in_seq ? 32'd3 : 32'd2);
      chk(bus_write == p_wr, "R2 direction", 32'(bus_write), 32'(p_wr));
      chk(bus_lock == !p_last, "R5 lock on beat", 32'(bus_lock), 32'(!p_last));
    end else begin
      chk(bus_trans == 2'b00, "R10 idle without take", 32'(bus_trans), 32'd0);
      chk(bus_lock == b_in_seq, "R5 lock in gap", 32'(bus_lock), 32'(b_in_seq));
    end
    if (p_ready && !p_err && active(p_trans) && p_bwrite)
      chk(bus_wdata == wpat(p_baddr), "R8 write data", bus_wdata, wpat(p_baddr));
    if (p_rvld)
      chk(lrsp_rdata == rpat(p_dp_a), "R9 read data", lrsp_rdata, rpat(p_dp_a));
    // model update
    if (p_ready) begin
      if (p_err) begin
        b_in_seq = 0; b_dp_v = 0;
      end else begin
        if (p_take) b_in_seq = !p_last;
        b_dp_v = active(p_trans); b_dp_w = p_bwrite; b_dp_a = p_baddr;
      end
    end
    if (p_err) b_hold = 1;
    else if (!p_valid) b_hold = 0;
    // driver update
    if (p_err) begin
      seq_left = 0; gap_left = 1;
    end else if (p_take) begin
      seq_left--; seq_addr += 32'd4;
      if (seq_left == 0) gap_left = int'($urandom % 3);
    end
  endtask

  task automatic step();
    bit e_err, e_req, e_take, e_rvld;
    @(negedge clk);
    if (have_prev) check_after();
    if (seq_left == 0) begin
      if (gap_left > 0) gap_left--;
      else begin
        seq_left = 1 + int'($urandom % 4);
        seq_addr = $urandom & 32'hFFFF_FFFC;
        seq_wr   = $urandom % 2;
      end
    end
    lreq_valid = (seq_left > 0);
    lreq_addr  = (seq_left > 0) ? seq_addr : $urandom;
    lreq_wdata = wpat(lreq_addr);
    lreq_wr    = seq_wr;
    lreq_rd    = !seq_wr;
    lreq_last  = (seq_left == 1);
    bus_gnt    = (($urandom % 100) < gnt_pct);
    if (err_phase == 2) begin
      bus_resp = 2'b01; bus_ready = 1'b1; err_phase = 0;
    end else if (b_dp_v && (($urandom % 100) < err_pct)) begin
      bus_resp = 2'b01; bus_ready = 1'b0; err_phase = 2;
    end else begin
      bus_resp = 2'b00; bus_ready = (($urandom % 100) < rdy_pct);
    end
    bus_rdata = rpat(b_dp_a);
    #1;
    e_err  = b_dp_v && bus_ready && bus_resp == 2'b01;
    e_req  = lreq_valid && !b_hold && !e_err;
    e_take = bus_ready && bus_gnt && e_req;
    e_rvld = b_dp_v && !b_dp_w && bus_ready && bus_resp == 2'b00;
    chk(bus_req == e_req, "R1 bus request", 32'(bus_req), 32'(e_req));
    chk(lreq_addr_take == e_take, "R7 address take", 32'(lreq_addr_take), 32'(e_take));
    chk(lreq_wdata_take == (e_take && seq_wr), "R8 write data take",
        32'(lreq_wdata_take), 32'(e_take && seq_wr));
    chk(lrsp_rdata_vld == e_rvld, "R9 read valid", 32'(lrsp_rdata_vld), 32'(e_rvld));
    chk(bus_size == 3'b010, "R3 word size", 32'(bus_size), 32'd2);
    p_ready = bus_ready; p_err = e_err; p_take = e_take; p_wr = seq_wr;
    p_last = lreq_last; p_rvld = e_rvld; p_valid = lreq_valid; p_addr = lreq_addr;
    p_trans = bus_trans; p_baddr = bus_addr; p_bwrite = bus_write; p_block = bus_lock;
    p_bwdata = bus_wdata; p_dp_a = b_dp_a;
    have_prev = 1;
  endtask

  task automatic run(input int n, input int g, input int r, input int e);
    gnt_pct = g; rdy_pct = r; err_pct = e;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; lreq_valid = 0; lreq_wr = 0; lreq_rd = 0; lreq_last = 0;
    lreq_addr = '0; lreq_wdata = '0; bus_gnt = 0; bus_ready = 1; bus_resp = 0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    // R12
    chk(bus_trans == 2'b00 && bus_lock == 0 && bus_req == 0, "R12 reset control",
        {29'd0, bus_trans, bus_lock}, 32'd0);
    chk(bus_addr == 0 && bus_write == 0, "R12 reset address", bus_addr, 32'd0);
    chk(bus_wdata == 0 && lrsp_rdata == 0, "R12 reset data", bus_wdata | lrsp_rdata, 32'd0);
    rst_n = 1'b1;
    run(400, 100, 100, 0);   // full throughput, back-to-back beats
    run(800, 70, 60, 0);     // mixed grant loss and wait states
    run(300, 90, 15, 0);     // long wait-state runs
    run(1200, 85, 80, 8);    // error responses injected
    run(400, 40, 90, 3);     // sparse grant with errors
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule